// File: doc/BRIEF.md
# Coherence Directory Lookup Controller

This block is a small ownership directory. It keeps one entry per tracked cache block, and each entry holds the block address, a coherence state code and the number of the core that holds the copy. Cores place lookup requests on a shared coherence request bus. The directory searches every entry at once and answers on the reply side with a confirmation. On a hit the confirmation carries the holder's core number, so the requester can talk to that core directly instead of broadcasting.

Messages on the bus carry a one-bit phase. Requests use phase 0 and confirmations use phase 1. The directory handles one request at a time. It raises a busy flag from the moment it accepts a request until its confirmation is taken with a ready handshake.

A separate update port keeps the table current. It can write an entry, which either refreshes an existing address or allocates a new one, and it can remove an entry. When the table is full, a new allocation replaces the entry at a rotating victim pointer.

Top module: `coh_dir_top`

## Requirements
- R1: After a synchronous active-low reset, rsp_valid and req_busy are 0 and the table is empty, so any lookup answers with a miss.
- R2: A request is accepted on a rising edge where req_valid=1, req_phase=0 and req_busy=0. Its confirmation shows rsp_valid=1 on the second rising edge after the accepting edge. req_busy is 1 from the first edge after acceptance.
- R3: A confirmation has rsp_phase=1, rsp_src equal to the requester's req_core and rsp_cat equal to its req_cat (0 = read, 1 = write).
- R4: On a hit, rsp_ack=0 and rsp_holder and rsp_state are the holder core number and state code stored for that address.
- R5: On a miss, rsp_ack=1 and rsp_holder and rsp_state are 0.
- R6: A message with req_phase=1 is never acted on: no confirmation appears and req_busy stays 0.
- R7: A confirmation holds all of its fields steady until a rising edge with rsp_ready=1. rsp_valid is 0 after that edge, and each accepted request yields exactly one confirmation.
- R8: While req_busy=1, any request on the bus is ignored and produces no confirmation later.
- R9: upd_op=01 (write) on an absent address allocates the lowest-numbered free entry, and later lookups hit it. upd_op=00 and upd_op=11 change nothing.
- R10: upd_op=01 on an address already present overwrites that entry's holder and state. No second entry is made, and no other entry is displaced, even when the table is full.
- R11: upd_op=10 (remove) makes later lookups of that address miss. Removing an absent address changes nothing.
- R12: upd_op=01 on an absent address while every entry is valid replaces the entry at the victim pointer. The pointer starts at entry 0 after reset and advances by one, wrapping, only on such a replacement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A message is on the request bus |
| req_phase | input | 1 | Message phase: 0 request, 1 confirmation |
| req_cat | input | 1 | Request category: 0 read, 1 write |
| req_core | input | CID_W | Requesting core number |
| req_addr | input | ADDR_W | Block address to look up |
| req_busy | output | 1 | A request is in flight, so new requests are ignored |
| rsp_valid | output | 1 | Confirmation present |
| rsp_phase | output | 1 | Confirmation phase, 1 while valid |
| rsp_cat | output | 1 | Echoed request category |
| rsp_src | output | CID_W | Echoed requester core number |
| rsp_ack | output | 1 | 0 on a hit, 1 on a miss |
| rsp_holder | output | CID_W | Holder core number on a hit |
| rsp_state | output | ST_W | Stored state code on a hit |
| rsp_ready | input | 1 | Confirmation taken on this edge |
| upd_valid | input | 1 | Table update strobe |
| upd_op | input | 2 | 01 write, 10 remove, 00 and 11 no operation |
| upd_addr | input | ADDR_W | Address to update |
| upd_holder | input | CID_W | Holder core number to store |
| upd_state | input | ST_W | State code to store |

## Verification
A stale or lost valid bit in the table shows up at the next lookup of the affected address. The confirmation carries the wrong acknowledge, two edges after that request is accepted. A wrong holder or state field shows up in that same confirmation. A victim pointer that is out of step stays hidden until the table is full and a new address is written. After that, the wrong surviving address answers a hit, so the sweeps look up every address after each eviction. A stuck busy or reply flag shows within one cycle, either as a confirmation no request asked for or as a request that never gets an answer.

// File: rtl/coh_dir_pkg.sv
`timescale 1ns/1ps
// Package: shared encodings for the coherence directory.
// Assumes: the phase and acknowledge encodings are fixed by the bus agents.
package coh_dir_pkg;
    typedef enum logic [1:0] {
        UPD_NOP = 2'b00,
        UPD_SET = 2'b01,
        UPD_DEL = 2'b10,
        UPD_RSV = 2'b11
    } upd_op_e;

    localparam logic PHASE_REQ  = 1'b0;
    localparam logic PHASE_CONF = 1'b1;
    localparam logic ACK_HIT    = 1'b0;
    localparam logic ACK_MISS   = 1'b1;
endpackage

// File: rtl/coh_dir_store.sv
`timescale 1ns/1ps
// Module: coh_dir_store
// Fully associative entry table with a parallel lookup compare and an update port.
// Assumes: each address is present at most once. Write refreshes a match and
// allocates otherwise. Remove clears matching entries.
module coh_dir_store
    import coh_dir_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 16,
    parameter int CID_W  = 2,
    parameter int ST_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic [DEPTH-1:0]  lk_hit_vec,
    output logic              lk_hit,
    output logic [CID_W-1:0]  lk_holder,
    output logic [ST_W-1:0]   lk_state,
    input  logic              upd_valid,
    input  logic [1:0]        upd_op,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic [CID_W-1:0]  upd_holder,
    input  logic [ST_W-1:0]   upd_state
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    logic [DEPTH-1:0]  ent_v;
    logic [ADDR_W-1:0] ent_addr [DEPTH];
    logic [CID_W-1:0]  ent_hold [DEPTH];
    logic [ST_W-1:0]   ent_st   [DEPTH];
    logic [DEPTH-1:0]  upd_vec;
    logic [IDX_W-1:0]  rr_ptr, free_idx, upd_idx, tgt_idx;
    logic              free_found, upd_hit;

    // One comparator pair per entry: lookup match and update match.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign lk_hit_vec[g] = ent_v[g] && (ent_addr[g] == lk_addr);
        assign upd_vec[g]    = ent_v[g] && (ent_addr[g] == upd_addr);
    end

    assign lk_hit  = |lk_hit_vec;
    assign upd_hit = |upd_vec;

    // Merge the fields of the single matching entry onto the lookup result.
    always_comb begin
        lk_holder = '0;
        lk_state  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (lk_hit_vec[i]) begin
                lk_holder = lk_holder | ent_hold[i];
                lk_state  = lk_state | ent_st[i];
            end
        end
    end

    // Find the lowest free entry and the index of an update match.
    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        upd_idx    = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!ent_v[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
            if (upd_vec[i]) begin
                upd_idx = IDX_W'(i);
            end
        end
    end

    // Choose the entry a write lands in: the match, then a free entry, then the victim.
    always_comb begin
        if (upd_hit)         tgt_idx = upd_idx;
        else if (free_found) tgt_idx = free_idx;
        else                 tgt_idx = rr_ptr;
    end

    // Valid bits and the victim pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_v  <= '0;
            rr_ptr <= '0;
        end else if (upd_valid) begin
            case (upd_op)
                UPD_SET: begin
                    ent_v[tgt_idx] <= 1'b1;
                    if (!upd_hit && !free_found)
                        rr_ptr <= (rr_ptr == LAST_IDX) ? '0 : rr_ptr + 1'b1;
                end
                UPD_DEL: ent_v <= ent_v & ~upd_vec;
                default: ;
            endcase
        end
    end

    // Entry payload, written only by a write update. Valid bits gate it on read.
    always_ff @(posedge clk) begin
        if (upd_valid && upd_op == UPD_SET) begin
            ent_addr[tgt_idx] <= upd_addr;
            ent_hold[tgt_idx] <= upd_holder;
            ent_st[tgt_idx]   <= upd_state;
        end
    end
endmodule

// File: rtl/coh_dir_reply.sv
`timescale 1ns/1ps
// Module: coh_dir_reply
// Captures one phase-0 request, presents its address to the table for one
// cycle, then registers and holds the confirmation until ready.
// Assumes: the table result is valid in the cycle after capture.
module coh_dir_reply
    import coh_dir_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CID_W  = 2,
    parameter int ST_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_phase,
    input  logic              req_cat,
    input  logic [CID_W-1:0]  req_core,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_busy,
    output logic [ADDR_W-1:0] lk_addr,
    input  logic              lk_hit,
    input  logic [CID_W-1:0]  lk_holder,
    input  logic [ST_W-1:0]   lk_state,
    output logic              rsp_valid,
    output logic              rsp_phase,
    output logic              rsp_cat,
    output logic [CID_W-1:0]  rsp_src,
    output logic              rsp_ack,
    output logic [CID_W-1:0]  rsp_holder,
    output logic [ST_W-1:0]   rsp_state,
    input  logic              rsp_ready
);
    logic             cap_v, cap_cat, accept;
    logic [CID_W-1:0] cap_core;

    assign req_busy  = cap_v | rsp_valid;
    assign accept    = req_valid && (req_phase == PHASE_REQ) && !req_busy;
    assign rsp_phase = rsp_valid ? PHASE_CONF : PHASE_REQ;

    // Capture stage: hold the request for the single search cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_v    <= 1'b0;
            cap_cat  <= 1'b0;
            cap_core <= '0;
            lk_addr  <= '0;
        end else begin
            cap_v <= accept;
            if (accept) begin
                cap_cat  <= req_cat;
                cap_core <= req_core;
                lk_addr  <= req_addr;
            end
        end
    end

    // Reply stage: form the confirmation from the search, hold it until taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_cat    <= 1'b0;
            rsp_src    <= '0;
            rsp_ack    <= ACK_MISS;
            rsp_holder <= '0;
            rsp_state  <= '0;
        end else if (cap_v) begin
            rsp_valid  <= 1'b1;
            rsp_cat    <= cap_cat;
            rsp_src    <= cap_core;
            rsp_ack    <= lk_hit ? ACK_HIT : ACK_MISS;
            rsp_holder <= lk_hit ? lk_holder : '0;
            rsp_state  <= lk_hit ? lk_state : '0;
        end else if (rsp_valid && rsp_ready) begin
            rsp_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/coh_dir_top.sv
`timescale 1ns/1ps
// Module: coh_dir_top
// Coherence directory: answers owner lookups from the request bus and keeps
// its table current through the update port.
// Assumes: one request in flight at a time, and updates never duplicate an address.
module coh_dir_top
    import coh_dir_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 16,
    parameter int CID_W  = 2,
    parameter int ST_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_phase,
    input  logic              req_cat,
    input  logic [CID_W-1:0]  req_core,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_busy,
    output logic              rsp_valid,
    output logic              rsp_phase,
    output logic              rsp_cat,
    output logic [CID_W-1:0]  rsp_src,
    output logic              rsp_ack,
    output logic [CID_W-1:0]  rsp_holder,
    output logic [ST_W-1:0]   rsp_state,
    input  logic              rsp_ready,
    input  logic              upd_valid,
    input  logic [1:0]        upd_op,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic [CID_W-1:0]  upd_holder,
    input  logic [ST_W-1:0]   upd_state
);
    logic [ADDR_W-1:0] lk_addr;
    logic [DEPTH-1:0]  lk_hit_vec;
    logic              lk_hit;
    logic [CID_W-1:0]  lk_holder;
    logic [ST_W-1:0]   lk_state;

    coh_dir_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CID_W(CID_W), .ST_W(ST_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .lk_addr(lk_addr), .lk_hit_vec(lk_hit_vec), .lk_hit(lk_hit),
        .lk_holder(lk_holder), .lk_state(lk_state),
        .upd_valid(upd_valid), .upd_op(upd_op), .upd_addr(upd_addr),
        .upd_holder(upd_holder), .upd_state(upd_state)
    );

    coh_dir_reply #(.ADDR_W(ADDR_W), .CID_W(CID_W), .ST_W(ST_W)) u_reply (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_phase(req_phase), .req_cat(req_cat),
        .req_core(req_core), .req_addr(req_addr), .req_busy(req_busy),
        .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_holder(lk_holder), .lk_state(lk_state),
        .rsp_valid(rsp_valid), .rsp_phase(rsp_phase), .rsp_cat(rsp_cat),
        .rsp_src(rsp_src), .rsp_ack(rsp_ack), .rsp_holder(rsp_holder),
        .rsp_state(rsp_state), .rsp_ready(rsp_ready)
    );
endmodule

// File: rtl/coh_dir_chk.sv
`timescale 1ns/1ps
// Module: coh_dir_chk
// Protocol and table checks for coh_dir_top, attached by bind.
// Assumes: it observes top-level ports plus the per-entry lookup match vector.
module coh_dir_chk #(
    parameter int DEPTH = 16,
    parameter int CID_W = 2,
    parameter int ST_W  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_phase,
    input logic [CID_W-1:0] req_core,
    input logic             req_busy,
    input logic             rsp_valid,
    input logic             rsp_phase,
    input logic [CID_W-1:0] rsp_src,
    input logic             rsp_ack,
    input logic [CID_W-1:0] rsp_holder,
    input logic [ST_W-1:0]  rsp_state,
    input logic             rsp_ready,
    input logic [DEPTH-1:0] hit_vec
);
    // R1: reset leaves no reply and no busy.
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!rsp_valid && !req_busy));

    // R2, R3: an accepted request is answered two edges later with its own core number.
    assert_reply_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_phase && !req_busy) |=> ##1 (rsp_valid && rsp_phase && rsp_src == $past(req_core, 2)));

    // R5: a miss carries zero holder and state.
    assert_miss_fields_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ack) |-> (rsp_holder == '0 && rsp_state == '0));

    // R6: a phase-1 message seen while idle starts nothing.
    assert_phase1_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_phase && !req_busy) |=> !req_busy);

    // R7: a waiting confirmation holds still.
    assert_reply_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_src) && $stable(rsp_ack)
                                       && $stable(rsp_holder) && $stable(rsp_state)));

    // R8: a pending confirmation always keeps the bus blocked.
    assert_busy_cover_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> req_busy);

    // R10: no address is ever held by more than one entry.
    assert_single_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
endmodule

bind coh_dir_top coh_dir_chk #(.DEPTH(DEPTH), .CID_W(CID_W), .ST_W(ST_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_phase(req_phase),
    .req_core(req_core), .req_busy(req_busy), .rsp_valid(rsp_valid),
    .rsp_phase(rsp_phase), .rsp_src(rsp_src), .rsp_ack(rsp_ack),
    .rsp_holder(rsp_holder), .rsp_state(rsp_state), .rsp_ready(rsp_ready),
    .hit_vec(lk_hit_vec)
);

// File: tb/coh_dir_top_bench.sv
`timescale 1ns/1ps
// Bench: fills, refreshes, evicts and removes entries, then sweeps every
// address against a model of the requirements.
module coh_dir_top_bench;
    localparam int DEPTH  = 16;
    localparam int ADDR_W = 8;
    localparam int CID_W  = 2;
    localparam int ST_W   = 3;
    localparam int NADDR  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0, req_phase = 1'b0, req_cat = 1'b0;
    logic [CID_W-1:0]  req_core = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_busy, rsp_valid, rsp_phase, rsp_cat, rsp_ack;
    logic [CID_W-1:0]  rsp_src, rsp_holder;
    logic [ST_W-1:0]   rsp_state;
    logic              rsp_ready = 1'b0;
    logic              upd_valid = 1'b0;
    logic [1:0]        upd_op = 2'b00;
    logic [ADDR_W-1:0] upd_addr = '0;
    logic [CID_W-1:0]  upd_holder = '0;
    logic [ST_W-1:0]   upd_state = '0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Requirement model of the table.
    bit m_v    [DEPTH];
    int m_addr [DEPTH];
    int m_hold [DEPTH];
    int m_st   [DEPTH];
    int m_rr = 0;

    always #4 clk = ~clk;

    coh_dir_top #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CID_W(CID_W), .ST_W(ST_W)) u_coh_dir_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_phase(req_phase),
        .req_cat(req_cat), .req_core(req_core), .req_addr(req_addr), .req_busy(req_busy),
        .rsp_valid(rsp_valid), .rsp_phase(rsp_phase), .rsp_cat(rsp_cat), .rsp_src(rsp_src),
        .rsp_ack(rsp_ack), .rsp_holder(rsp_holder), .rsp_state(rsp_state),
        .rsp_ready(rsp_ready), .upd_valid(upd_valid), .upd_op(upd_op),
        .upd_addr(upd_addr), .upd_holder(upd_holder), .upd_state(upd_state)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int mfind(input int a);
        int r = -1;
        for (int i = 0; i < DEPTH; i++) if (m_v[i] && m_addr[i] == a) r = i;
        return r;
    endfunction

    task automatic upd(input logic [1:0] op, input int a, input int h, input int s);
        int idx;
        @(negedge clk);
        upd_valid = 1'b1; upd_op = op; upd_addr = ADDR_W'(a);
        upd_holder = CID_W'(h); upd_state = ST_W'(s);
        @(negedge clk);
        upd_valid = 1'b0;
        idx = mfind(a);
        if (op == 2'b01) begin
            if (idx < 0) begin
                for (int i = DEPTH - 1; i >= 0; i--) if (!m_v[i]) idx = i;
                if (idx < 0) begin
                    idx = m_rr;
                    m_rr = (m_rr + 1) % DEPTH;
                end
            end
            m_v[idx] = 1'b1; m_addr[idx] = a; m_hold[idx] = h; m_st[idx] = s;
        end else if (op == 2'b10 && idx >= 0) begin
            m_v[idx] = 1'b0;
        end
    endtask

    // Lookup with model-based expectations; optional ready delay and a busy-time intruder.
    task automatic lookup(input int core, input int cat, input int a, input int wait_n,
                          input bit intrude, input string tag);
        int idx = mfind(a);
        int e_ack = (idx >= 0) ? 0 : 1;
        int e_h   = (idx >= 0) ? m_hold[idx] : 0;
        int e_s   = (idx >= 0) ? m_st[idx] : 0;
        @(negedge clk);
        req_valid = 1'b1; req_phase = 1'b0; req_core = CID_W'(core);
        req_cat = cat[0]; req_addr = ADDR_W'(a);
        @(negedge clk);
        check(!rsp_valid && req_busy, {tag, " R2 busy after accept"}, {rsp_valid, req_busy}, 1);
        if (intrude) begin
            req_core = CID_W'(core + 1); req_addr = ADDR_W'(a + 1);
        end else begin
            req_valid = 1'b0;
        end
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid == 1'b1, {tag, " R2 reply valid"}, rsp_valid, 1);
        check(rsp_phase == 1'b1 && rsp_src == CID_W'(core) && rsp_cat == cat[0],
              {tag, " R3 phase/src/cat"}, rsp_src, core);
        check(rsp_ack == e_ack[0], {tag, " R4/R5 ack"}, rsp_ack, e_ack);
        check(rsp_holder == CID_W'(e_h) && rsp_state == ST_W'(e_s),
              {tag, " R4/R5 holder"}, {rsp_holder, rsp_state}, (e_h << ST_W) | e_s);
        for (int k = 0; k < wait_n; k++) begin
            @(negedge clk);
            check(rsp_valid && rsp_src == CID_W'(core) && rsp_ack == e_ack[0],
                  {tag, " R7 held"}, rsp_valid, 1);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        check(!rsp_valid && !req_busy, {tag, " R7 released"}, {rsp_valid, req_busy}, 0);
        if (intrude) begin
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                check(!rsp_valid && !req_busy, {tag, " R8 intruder ignored"}, rsp_valid, 0);
            end
        end
    endtask

    task automatic sweep(input string tag);
        for (int a = 0; a < NADDR; a++) lookup(a % 4, (a >> 1) & 1, a, 0, 1'b0, tag);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) m_v[i] = 1'b0;
        repeat (3) @(negedge clk);
        check(!rsp_valid && !req_busy, "R1 reset outputs", {rsp_valid, req_busy}, 0);
        rst_n = 1'b1;
        lookup(1, 0, 5, 0, 1'b0, "R1 empty");
        lookup(2, 1, 255, 0, 1'b0, "R1 empty");

        // R6: phase-1 traffic for several cycles.
        @(negedge clk);
        req_valid = 1'b1; req_phase = 1'b1; req_addr = 8'd7;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(!rsp_valid && !req_busy, "R6 phase1 ignored", {rsp_valid, req_busy}, 0);
        end
        req_valid = 1'b0; req_phase = 1'b0;
        @(negedge clk);
        check(!rsp_valid && !req_busy, "R6 phase1 no late reply", rsp_valid, 0);

        // R9: reserved and no-op codes change nothing.
        upd(2'b11, 77, 3, 5);
        upd(2'b00, 78, 3, 5);
        lookup(0, 0, 77, 0, 1'b0, "R9 op11 no effect");
        lookup(0, 0, 78, 0, 1'b0, "R9 op00 no effect");

        // R9: fill every entry, then sweep all addresses.
        for (int i = 0; i < DEPTH; i++) upd(2'b01, (i * 37 + 5) % NADDR, i % 4, i % 8);
        sweep("R9 fill sweep");

        // R7, R8: delayed ready and an intruding request while busy.
        lookup(3, 1, 42, 3, 1'b0, "R7 delayed ready");
        lookup(1, 0, 79, 1, 1'b1, "R8 busy window");

        // R10: refresh an existing address while full.
        upd(2'b01, 116, 0, 6);
        lookup(2, 0, 116, 0, 1'b0, "R10 refresh");
        lookup(2, 0, 5, 0, 1'b0, "R10 no displacement");

        // R12: two evictions in victim order.
        upd(2'b01, 200, 1, 2);
        lookup(0, 1, 5, 0, 1'b0, "R12 first victim gone");
        lookup(0, 1, 200, 0, 1'b0, "R12 new entry");
        upd(2'b01, 201, 2, 3);
        lookup(0, 1, 42, 0, 1'b0, "R12 second victim gone");
        lookup(0, 1, 201, 0, 1'b0, "R12 second new entry");

        // R11: remove present and absent addresses.
        upd(2'b10, 153, 0, 0);
        upd(2'b10, 99, 0, 0);
        lookup(3, 0, 153, 0, 1'b0, "R11 removed");
        // R9: the freed entry is reused before the victim pointer moves.
        upd(2'b01, 99, 3, 7);
        lookup(3, 0, 99, 0, 1'b0, "R9 reuse free");
        lookup(3, 0, 79, 0, 1'b0, "R12 pointer untouched");
        sweep("R11 final sweep");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule